// File: doc/BRIEF.md
# Hypervisor-Aware Debug Event Controller

This block sits beside a processor core that runs in hypervisor, guest and user privilege states. It receives single-cycle debug event pulses from the core's detectors, such as address matches, taken branches and returns. It enables each event type separately and decides whether the current machine state allows the event to be recorded. Qualified events land in a sticky status register. Software clears that register by writing ones to it. Code in hypervisor state has a separate alias register that forces status bits to one.

The block also holds the machine-state debug-enable bit. A protect bit can stop guest code from changing it. A registered interrupt request tells the core that an enabled event is pending while debugging is enabled. Every register is reached through a small register port. That port carries the address, a write strobe, write data and the current privilege state. Read data is registered.

Top module: `dbgevt_top`

## Requirements
- R1: After reset every register reads zero and `dbgIrq` is 0.
- R2: Each event has its own enable. Events 0 to LO_W-1 are enabled by bit i of the low enable register at address 0. The remaining events are enabled by bit (i-LO_W) of the high enable register at address 1. An enabled event pulse on `evtIn[i]` sets bit i of the status register at address 3. A disabled event leaves that bit clear.
- R3: Bit 0 of the hypervisor control register at address 2 discards events unless `coreGs`=1. Hypervisor state means `coreGs`=0 and `corePr`=0. When the bit is 0, events are recorded in every state.
- R4: The hypervisor control register at address 2 holds the discard bit (bit 0) and the debug-enable protect bit (bit 1). Only writes made in hypervisor state change it. Writes from any other state are ignored.
- R5: Status bits stay set until cleared. Writing 1 to a bit at address 3 clears it. Writing 0 leaves it unchanged.
- R6: The set register at address 4 has the status bit layout. In hypervisor state, writing 1 sets the matching status bit and writing 0 changes nothing. Writes from guest or user state are ignored. The register reads back as zero.
- R7: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The debug-enable bit is bit 0 at address 5. When the protect bit is 1, a write made with `coreGs`=1 is ignored. Any other write loads the bit.
- R9: `dbgIrq` is a register that equals, one cycle later, debug-enable AND (any status bit whose event is enabled). It falls on the second clock edge after the write that clears the last such bit.
- R10: `regRData` shows the register addressed at the previous clock edge. Unmapped addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_EVT | Raw event pulses from the core detectors |
| coreGs | input | 1 | Guest-state machine bit |
| corePr | input | 1 | Problem (user) state machine bit |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe |
| regWData | input | DW | Write data |
| regRData | output | DW | Read data, registered |
| dbgIrq | output | 1 | Debug interrupt request |

## Verification
The hardest case to reach is a hardware event and a software clear landing on the same status bit in one cycle. The bench reaches it by raising the event pulse and the write strobe at the same falling edge. Separately, the event sweep drives each event through every combination of guest and problem state, discard bit and enable. This reaches the hypervisor-user and guest-user corners that ordinary code seldom visits. The interrupt fall is sampled on the two falling edges that follow the clear. This pins down the exact one-cycle lag.

// File: rtl/dbgevt_pkg.sv
package dbgevt_pkg;
  typedef enum logic [2:0] {
    A_ENLO = 3'd0,
    A_ENHI = 3'd1,
    A_HCTL = 3'd2,
    A_STAT = 3'd3,
    A_SETR = 3'd4,
    A_MST  = 3'd5
  } regAddrE;

  typedef struct packed {
    logic wrEnLo;
    logic wrEnHi;
    logic wrHctl;
    logic wrStat;
    logic wrSet;
    logic wrDe;
  } strobeT;
endpackage

// File: rtl/dbgevt_ctrl.sv
module dbgevt_ctrl
  import dbgevt_pkg::*;
(
  input  logic       regWr,
  input  logic [2:0] regAddr,
  input  logic       coreGs,
  input  logic       corePr,
  input  logic       deProt,
  output strobeT     stb
);
  logic isHyp;
  logic deBlocked;

  assign isHyp     = !coreGs && !corePr;
  assign deBlocked = coreGs && deProt;

  always_comb begin
    stb        = '0;
    stb.wrEnLo = regWr && (regAddr == A_ENLO);
    stb.wrEnHi = regWr && (regAddr == A_ENHI);
    stb.wrHctl = regWr && (regAddr == A_HCTL) && isHyp;
    stb.wrStat = regWr && (regAddr == A_STAT);
    stb.wrSet  = regWr && (regAddr == A_SETR) && isHyp;
    stb.wrDe   = regWr && (regAddr == A_MST) && !deBlocked;
  end
endmodule

// File: rtl/dbgevt_dp.sv
module dbgevt_dp
  import dbgevt_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int LO_W    = 4,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [DW-1:0]      wrData,
  input  logic [2:0]         regAddr,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               coreGs,
  output logic [DW-1:0]      rdData,
  output logic               irqQ,
  output logic [NUM_EVT-1:0] statQ,
  output logic [NUM_EVT-1:0] enAll,
  output logic               deQ,
  output logic               hypOffQ,
  output logic               deProtQ
);
  localparam int HI_W = NUM_EVT - LO_W;

  logic [LO_W-1:0]    enLoQ;
  logic [HI_W-1:0]    enHiQ;
  logic [NUM_EVT-1:0] qualEvt;
  logic [NUM_EVT-1:0] setMask;
  logic [NUM_EVT-1:0] clrMask;
  logic [NUM_EVT-1:0] statNext;
  logic               stateOk;
  logic [DW-1:0]      rdNext;

  assign enAll   = {enHiQ, enLoQ};
  assign stateOk = !hypOffQ || coreGs;
  assign qualEvt = evtIn & enAll & {NUM_EVT{stateOk}};
  assign setMask = stb.wrSet  ? wrData[NUM_EVT-1:0] : '0;
  assign clrMask = stb.wrStat ? wrData[NUM_EVT-1:0] : '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
    // a set source beats a clear on the same bit
    assign statNext[i] = qualEvt[i] || setMask[i] || (statQ[i] && !clrMask[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLoQ   <= '0;
      enHiQ   <= '0;
      hypOffQ <= 1'b0;
      deProtQ <= 1'b0;
      deQ     <= 1'b0;
      statQ   <= '0;
      irqQ    <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.wrEnLo) enLoQ <= wrData[LO_W-1:0];
      if (stb.wrEnHi) enHiQ <= wrData[HI_W-1:0];
      if (stb.wrHctl) begin
        hypOffQ <= wrData[0];
        deProtQ <= wrData[1];
      end
      if (stb.wrDe) deQ <= wrData[0];
      statQ  <= statNext;
      irqQ   <= deQ && |(statQ & enAll);
      rdData <= rdNext;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_ENLO:  rdNext = DW'(enLoQ);
      A_ENHI:  rdNext = DW'(enHiQ);
      A_HCTL:  rdNext = DW'({deProtQ, hypOffQ});
      A_STAT:  rdNext = DW'(statQ);
      A_MST:   rdNext = DW'(deQ);
      default: rdNext = '0;
    endcase
  end
endmodule

// File: rtl/dbgevt_top.sv
module dbgevt_top
  import dbgevt_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int LO_W    = 4,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               coreGs,
  input  logic               corePr,
  input  logic [2:0]         regAddr,
  input  logic               regWr,
  input  logic [DW-1:0]      regWData,
  output logic [DW-1:0]      regRData,
  output logic               dbgIrq
);
  strobeT             stb;
  logic [NUM_EVT-1:0] statQ;
  logic [NUM_EVT-1:0] enAll;
  logic               deQ;
  logic               hypOffQ;
  logic               deProtQ;

  dbgevt_ctrl u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .coreGs  (coreGs),
    .corePr  (corePr),
    .deProt  (deProtQ),
    .stb     (stb)
  );

  dbgevt_dp #(.NUM_EVT(NUM_EVT), .LO_W(LO_W), .DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWData),
    .regAddr (regAddr),
    .evtIn   (evtIn),
    .coreGs  (coreGs),
    .rdData  (regRData),
    .irqQ    (dbgIrq),
    .statQ   (statQ),
    .enAll   (enAll),
    .deQ     (deQ),
    .hypOffQ (hypOffQ),
    .deProtQ (deProtQ)
  );
endmodule

// File: rtl/dbgevt_chk.sv
module dbgevt_chk
  import dbgevt_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int DW      = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               coreGs,
  input logic               corePr,
  input logic [2:0]         regAddr,
  input logic               regWr,
  input logic [DW-1:0]      regWData,
  input logic               dbgIrq,
  input logic [NUM_EVT-1:0] stat,
  input logic [NUM_EVT-1:0] enAll,
  input logic               de,
  input logic               hypOff,
  input logic               deProt
);
  logic               inHyp;
  logic [NUM_EVT-1:0] liveEvt;
  logic [NUM_EVT-1:0] clrReq;

  assign inHyp   = !coreGs && !corePr;
  assign liveEvt = (!hypOff || coreGs) ? (evtIn & enAll) : '0;
  assign clrReq  = (regWr && regAddr == A_STAT) ? regWData[NUM_EVT-1:0] : '0;

  // R2
  evt_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveEvt != '0) |=> ((stat & $past(liveEvt)) == $past(liveEvt)));

  // R3
  hyp_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hypOff && !coreGs && !(regWr && regAddr == A_SETR)) |=> ((stat & ~$past(stat)) == '0));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stat) & ~$past(clrReq) & ~stat) == '0);

  // R6
  set_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_SETR && !inHyp && evtIn == '0) |=> ((stat & ~$past(stat)) == '0));

  // R8
  de_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_MST && coreGs && deProt) |=> $stable(de));

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgIrq == $past(de && ((stat & enAll) != '0)));
endmodule

bind dbgevt_top dbgevt_chk #(.NUM_EVT(NUM_EVT), .DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .coreGs   (coreGs),
  .corePr   (corePr),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .regWData (regWData),
  .dbgIrq   (dbgIrq),
  .stat     (statQ),
  .enAll    (enAll),
  .de       (deQ),
  .hypOff   (hypOffQ),
  .deProt   (deProtQ)
);

// File: tb/dbgevt_top_tb.sv
`timescale 1ns/1ps
module dbgevt_top_tb;
  localparam int NE = 8;
  localparam int LW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NE-1:0] evtIn = '0;
  logic          coreGs = 1'b0;
  logic          corePr = 1'b0;
  logic [2:0]    regAddr = '0;
  logic          regWr = 1'b0;
  logic [DW-1:0] regWData = '0;
  logic [DW-1:0] regRData;
  logic          dbgIrq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbgevt_top #(.NUM_EVT(NE), .LO_W(LW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .coreGs(coreGs), .corePr(corePr),
    .regAddr(regAddr), .regWr(regWr), .regWData(regWData),
    .regRData(regRData), .dbgIrq(dbgIrq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic gs, input logic pr);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1; coreGs = gs; corePr = pr;
    @(negedge clk);
    regWr = 1'b0; coreGs = 1'b0; corePr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    regAddr = a;
    @(negedge clk);
    d = regRData;
  endtask

  task automatic pulse(input logic [NE-1:0] m, input logic gs, input logic pr);
    @(negedge clk);
    evtIn = m; coreGs = gs; corePr = pr;
    @(negedge clk);
    evtIn = '0; coreGs = 1'b0; corePr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values, R10 unmapped reads
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(a > 5 ? "R10 unmapped" : "R1 reset", d, '0);
    end
    chk("R1 irq", DW'(dbgIrq), '0);

    // R2 / R3 sweep: event x state x discard x enable
    for (int ev = 0; ev < NE; ev++)
      for (int st = 0; st < 4; st++)
        for (int ho = 0; ho < 2; ho++)
          for (int en = 0; en < 2; en++) begin
            wr(3'd3, '1, 1'b0, 1'b0);
            wr(3'd2, DW'(ho), 1'b0, 1'b0);
            wr(3'd0, (en == 1 && ev < LW) ? DW'(1 << ev) : '0, 1'b0, 1'b0);
            wr(3'd1, (en == 1 && ev >= LW) ? DW'(1 << (ev - LW)) : '0, 1'b0, 1'b0);
            pulse(NE'(1 << ev), st[1], st[0]);
            rd(3'd3, d);
            e = (en == 1 && (ho == 0 || st[1] == 1'b1)) ? DW'(1 << ev) : '0;
            chk(ho == 1 ? "R3 discard" : "R2 enable", d, e);
          end
    wr(3'd2, '0, 1'b0, 1'b0);

    // R5 write-1-to-clear sweep; R6 set register reads zero
    for (int p = 0; p < 16; p++) begin
      logic [DW-1:0] cm;
      cm = {p[3:0], ~p[3:0]};
      wr(3'd4, '1, 1'b0, 1'b0);
      wr(3'd3, cm, 1'b0, 1'b0);
      rd(3'd3, d);
      chk("R5 w1c", d, ~cm);
    end
    rd(3'd4, d);
    chk("R6 readback", d, '0);

    // R6 privilege sweep on the set register
    for (int st = 0; st < 4; st++) begin
      wr(3'd3, '1, 1'b0, 1'b0);
      wr(3'd4, 8'hA5, st[1], st[0]);
      rd(3'd3, d);
      chk("R6 privilege", d, st == 0 ? 8'hA5 : 8'h00);
    end
    wr(3'd4, 8'hA5, 1'b0, 1'b0);
    wr(3'd4, 8'h00, 1'b0, 1'b0);
    rd(3'd3, d);
    chk("R6 zero write", d, 8'hA5);

    // R4 hypervisor control register write guard
    for (int st = 0; st < 4; st++) begin
      wr(3'd2, '0, 1'b0, 1'b0);
      wr(3'd2, 8'h03, st[1], st[0]);
      rd(3'd2, d);
      chk("R4 hctl guard", d, st == 0 ? 8'h03 : 8'h00);
    end
    wr(3'd2, '0, 1'b0, 1'b0);

    // R7 event and clear on the same bit in one cycle
    wr(3'd0, 8'h0F, 1'b0, 1'b0);
    wr(3'd1, 8'h0F, 1'b0, 1'b0);
    wr(3'd4, 8'h06, 1'b0, 1'b0);
    @(negedge clk);
    regAddr = 3'd3; regWData = '1; regWr = 1'b1; evtIn = 8'h04;
    @(negedge clk);
    regWr = 1'b0; evtIn = '0;
    rd(3'd3, d);
    chk("R7 set wins", d, 8'h04);

    // R8 debug-enable protect sweep
    for (int pr = 0; pr < 2; pr++)
      for (int st = 0; st < 4; st++)
        for (int iv = 0; iv < 2; iv++) begin
          wr(3'd2, DW'(pr << 1), 1'b0, 1'b0);
          wr(3'd5, DW'(iv), 1'b0, 1'b0);
          wr(3'd5, DW'(1 - iv), st[1], st[0]);
          rd(3'd5, d);
          e = (pr == 1 && st[1] == 1'b1) ? DW'(iv) : DW'(1 - iv);
          chk("R8 de protect", d, e);
        end
    wr(3'd2, '0, 1'b0, 1'b0);

    // R9 interrupt timing and gating
    wr(3'd3, '1, 1'b0, 1'b0);
    wr(3'd0, 8'h01, 1'b0, 1'b0);
    wr(3'd1, 8'h00, 1'b0, 1'b0);
    wr(3'd5, 8'h01, 1'b0, 1'b0);
    wr(3'd4, 8'h01, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 irq rise", DW'(dbgIrq), 8'h01);
    @(negedge clk);
    regAddr = 3'd3; regWData = 8'h01; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    chk("R9 irq lag", DW'(dbgIrq), 8'h01);
    @(negedge clk);
    chk("R9 irq fall", DW'(dbgIrq), 8'h00);
    wr(3'd4, 8'h02, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 disabled event", DW'(dbgIrq), 8'h00);
    wr(3'd4, 8'h01, 1'b0, 1'b0);
    wr(3'd5, 8'h00, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 de off", DW'(dbgIrq), 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule